// File: doc/BRIEF.md
# Pending Transaction Status Table

This block is a small, fully associative table for a directory-based coherence controller. It holds one entry for each memory line whose coherence transaction is still in progress. A line that has an entry is, by definition, in a transient (non-stable) coherence state. Each entry carries the following fields:

- a valid flag
- the line's tag and set index
- the transient coherence state
- a sharer vector with one bit per tile
- the owner tile number

The issue logic presents the tag and set of several candidate messages at once, one on each lookup port. Each port returns combinationally:

- whether the line is tracked
- which slot holds it
- the slot's contents

The table also shows the lowest free slot and a full flag, so the issue logic can hold back new work when no slot is left.

A single write port changes the table at the clock edge, in one of three ways:

- **Allocation** writes the lowest free slot, which the table itself selects.
- **Update** writes the slot number given with the write. That number is normally the one an earlier lookup returned.
- **Release** is an indexed write with the valid flag cleared.

Lookups always read the registered contents. A lookup in the same cycle as a write therefore sees the table as it was before that write.

Top module: `pend_txn_table`

## Requirements
- R1: After reset every slot is empty: `full` is 0, `free_idx` is 0 and no lookup port reports a hit.
- R2: A lookup port reports a hit only when a valid slot has both the same tag and the same set as the query. A slot matching only the tag, or only the set, gives a miss.
- R3: When several valid slots match one query, the port reports the lowest-numbered matching slot.
- R4: On a hit, the port returns the matching slot's index, state, sharer vector and owner.
- R5: `free_idx` is the lowest-numbered slot whose valid flag is clear. `full` is 1 exactly when all slots are valid.
- R6: A write with `wr_en`=1 and `wr_alloc`=1 stores the write data into the slot shown on `free_idx` in that cycle. The change is visible to lookups from the next cycle.
- R7: A write with `wr_en`=1 and `wr_alloc`=0 stores the write data into slot `wr_idx` and leaves every other slot unchanged.
- R8: A write with `wr_valid`=0 releases the target slot. Later lookups of its address miss, and the slot becomes eligible as `free_idx`.
- R9: A lookup in the same cycle as a write to the looked-up slot returns the contents from before that write.
- R10: An allocation (`wr_alloc`=1) attempted while `full` is 1 changes no slot.
- R11: The lookup ports are independent. Each port answers its own query in the same cycle, whatever the other ports query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_tag | input | PORTS*TAG_W | Query tags, port p at bits [p*TAG_W +: TAG_W] |
| lk_set | input | PORTS*SET_W | Query set indices, port p at bits [p*SET_W +: SET_W] |
| lk_hit | output | PORTS | Hit flag per port |
| lk_idx | output | PORTS*IDX_W | Matching slot per port |
| lk_state | output | PORTS*STATE_W | Coherence state of the matching slot |
| lk_sharers | output | PORTS*TILES | Sharer vector of the matching slot |
| lk_owner | output | PORTS*OWNER_W | Owner tile of the matching slot |
| wr_en | input | 1 | Write strobe |
| wr_alloc | input | 1 | 1: target is `free_idx`; 0: target is `wr_idx` |
| wr_idx | input | IDX_W | Target slot for update or release |
| wr_valid | input | 1 | Valid flag written; 0 releases the slot |
| wr_tag | input | TAG_W | Tag written |
| wr_set | input | SET_W | Set index written |
| wr_state | input | STATE_W | Coherence state written |
| wr_sharers | input | TILES | Sharer vector written |
| wr_owner | input | OWNER_W | Owner tile written |
| free_idx | output | IDX_W | Lowest empty slot |
| full | output | 1 | All slots valid |

## Verification
The bench keeps the tag and set space tiny, so that partial matches and duplicate addresses come up constantly:

- **Partial matches.** Tag-only and set-only matches are generated often. A comparator that ignored one field would report false hits.
- **Duplicate addresses.** Duplicates leave several slots matching one query. A wrong priority would report the newer slot.
- **Same-cycle write and lookup.** Directed cases write a slot while a port looks it up. A bypassed or early-updated read path would return the new state one cycle too soon.
- **Allocation while full.** A missing guard would overwrite slot 0 or some other live slot, and a later lookup of a surviving line would then miss.
- **Release.** A release that failed to clear the flag would keep `free_idx` pointing past the hole.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int TAG_W   = 12;
  localparam int SET_W   = 6;
  localparam int STATE_W = 4;
  localparam int TILES   = 4;
  localparam int OWNER_W = (TILES > 1) ? $clog2(TILES) : 1;

  typedef struct packed {
    logic               valid;
    logic [TAG_W-1:0]   tag;
    logic [SET_W-1:0]   set;
    logic [STATE_W-1:0] state;
    logic [TILES-1:0]   sharers;
    logic [OWNER_W-1:0] owner;
  } slot_t;

  function automatic logic addr_match(input slot_t s, input logic [TAG_W-1:0] t,
                                      input logic [SET_W-1:0] st);
    return s.valid && (s.tag == t) && (s.set == st);
  endfunction
endpackage

// File: rtl/ptt_slot_store.sv
module ptt_slot_store
  import ptt_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  slot_t            wdata,
  output slot_t            slots_q [ENTRIES]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
    end else if (we) begin
      slots_q[widx] <= wdata;
    end
  end

  // R8
  dealloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata.valid) |=> !slots_q[$past(widx)].valid);

  // R7
  upd_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (slots_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/ptt_free_finder.sv
module ptt_free_finder #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   free_idx,
  output logic               full
);
  function automatic logic [IDX_W-1:0] lowest_clear(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES-1; i >= 0; i--) if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign free_idx = lowest_clear(valid_vec);
  assign full     = &valid_vec;

  // R5
  free_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[free_idx]);
endmodule

// File: rtl/ptt_lookup_port.sv
module ptt_lookup_port
  import ptt_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  slot_t            slots [ENTRIES],
  input  logic [TAG_W-1:0] q_tag,
  input  logic [SET_W-1:0] q_set,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output slot_t            data
);
  logic [ENTRIES-1:0] match_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) match_vec[i] = addr_match(slots[i], q_tag, q_set);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign data = hit ? slots[idx] : '0;
endmodule

// File: rtl/pend_txn_table.sv
module pend_txn_table
  import ptt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORTS   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORTS*TAG_W-1:0]   lk_tag,
  input  logic [PORTS*SET_W-1:0]   lk_set,
  output logic [PORTS-1:0]         lk_hit,
  output logic [PORTS*IDX_W-1:0]   lk_idx,
  output logic [PORTS*STATE_W-1:0] lk_state,
  output logic [PORTS*TILES-1:0]   lk_sharers,
  output logic [PORTS*OWNER_W-1:0] lk_owner,
  input  logic                     wr_en,
  input  logic                     wr_alloc,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_valid,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [SET_W-1:0]         wr_set,
  input  logic [STATE_W-1:0]       wr_state,
  input  logic [TILES-1:0]         wr_sharers,
  input  logic [OWNER_W-1:0]       wr_owner,
  output logic [IDX_W-1:0]         free_idx,
  output logic                     full
);
  slot_t              slots_q [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  slot_t              wdata;
  logic               do_write;
  logic [IDX_W-1:0]   tgt_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) valid_vec[i] = slots_q[i].valid;
  end

  assign wdata    = '{valid: wr_valid, tag: wr_tag, set: wr_set, state: wr_state,
                      sharers: wr_sharers, owner: wr_owner};
  assign tgt_idx  = wr_alloc ? free_idx : wr_idx;
  assign do_write = wr_en && !(wr_alloc && full);

  ptt_slot_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(do_write), .widx(tgt_idx), .wdata(wdata),
    .slots_q(slots_q));

  ptt_free_finder #(.ENTRIES(ENTRIES)) u_free (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .free_idx(free_idx), .full(full));

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    slot_t            pdata;
    logic             phit;
    logic [IDX_W-1:0] pidx;

    ptt_lookup_port #(.ENTRIES(ENTRIES)) u_lk (
      .slots(slots_q), .q_tag(lk_tag[p*TAG_W +: TAG_W]), .q_set(lk_set[p*SET_W +: SET_W]),
      .hit(phit), .idx(pidx), .data(pdata));

    assign lk_hit[p]                      = phit;
    assign lk_idx[p*IDX_W +: IDX_W]       = pidx;
    assign lk_state[p*STATE_W +: STATE_W] = pdata.state;
    assign lk_sharers[p*TILES +: TILES]   = pdata.sharers;
    assign lk_owner[p*OWNER_W +: OWNER_W] = pdata.owner;

    // R2
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phit |-> (valid_vec[pidx] && slots_q[pidx].tag == lk_tag[p*TAG_W +: TAG_W]
                && slots_q[pidx].set == lk_set[p*SET_W +: SET_W]));
  end

  // R10
  full_alloc_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_alloc && full) |=> $stable(valid_vec));

  // R6
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_alloc && !full && wr_valid) |=> valid_vec[$past(free_idx)]);
endmodule

// File: tb/pend_txn_table_bench.sv
module pend_txn_table_bench;
  import ptt_pkg::*;
  localparam int ENTRIES = 8;
  localparam int PORTS   = 3;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic [TAG_W-1:0]   q_tag [PORTS];
  logic [SET_W-1:0]   q_set [PORTS];
  logic [PORTS*TAG_W-1:0]   lk_tag;
  logic [PORTS*SET_W-1:0]   lk_set;
  logic [PORTS-1:0]         lk_hit;
  logic [PORTS*IDX_W-1:0]   lk_idx;
  logic [PORTS*STATE_W-1:0] lk_state;
  logic [PORTS*TILES-1:0]   lk_sharers;
  logic [PORTS*OWNER_W-1:0] lk_owner;
  logic wr_en = 0, wr_alloc = 0, wr_valid = 0;
  logic [IDX_W-1:0]   wr_idx = '0;
  logic [TAG_W-1:0]   wr_tag = '0;
  logic [SET_W-1:0]   wr_set = '0;
  logic [STATE_W-1:0] wr_state = '0;
  logic [TILES-1:0]   wr_sharers = '0;
  logic [OWNER_W-1:0] wr_owner = '0;
  logic [IDX_W-1:0]   free_idx;
  logic               full;

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      lk_tag[p*TAG_W +: TAG_W] = q_tag[p];
      lk_set[p*SET_W +: SET_W] = q_set[p];
    end
  end

  pend_txn_table #(.ENTRIES(ENTRIES), .PORTS(PORTS)) u_pend_txn_table (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_set(lk_set), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_sharers(lk_sharers), .lk_owner(lk_owner),
    .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_tag(wr_tag), .wr_set(wr_set), .wr_state(wr_state), .wr_sharers(wr_sharers),
    .wr_owner(wr_owner), .free_idx(free_idx), .full(full));

  // reference model
  bit m_v [ENTRIES];
  int m_tag [ENTRIES], m_set [ENTRIES], m_st [ENTRIES], m_sh [ENTRIES], m_ow [ENTRIES];
  int obs_hit [PORTS], obs_idx [PORTS], obs_st [PORTS];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  function automatic int m_free();
    for (int i = 0; i < ENTRIES; i++) if (!m_v[i]) return i;
    return 0;
  endfunction
  function automatic bit m_full();
    for (int i = 0; i < ENTRIES; i++) if (!m_v[i]) return 0;
    return 1;
  endfunction
  function automatic int m_find(int t, int s);
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_tag[i] == t && m_set[i] == s) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act,
                     input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // inputs set before call; compares outputs, crosses one edge, updates model
  task automatic step();
    int widx;
    #1;
    chk(free_idx == IDX_W'(m_free()), "R5", "free_idx", int'(free_idx), m_free());
    chk(full == m_full(), "R5", "full", int'(full), int'(m_full()));
    for (int p = 0; p < PORTS; p++) begin
      int e;
      e = m_find(int'(q_tag[p]), int'(q_set[p]));
      obs_hit[p] = int'(lk_hit[p]);
      obs_idx[p] = int'(lk_idx[p*IDX_W +: IDX_W]);
      obs_st[p]  = int'(lk_state[p*STATE_W +: STATE_W]);
      chk(obs_hit[p] == (e >= 0 ? 1 : 0), "R2", "hit (R11 per port)", obs_hit[p], e >= 0 ? 1 : 0);
      if (e >= 0) begin
        chk(obs_idx[p] == e, "R3", "idx", obs_idx[p], e);
        chk(obs_st[p] == m_st[e], "R4", "state", obs_st[p], m_st[e]);
        chk(int'(lk_sharers[p*TILES +: TILES]) == m_sh[e], "R4", "sharers",
            int'(lk_sharers[p*TILES +: TILES]), m_sh[e]);
        chk(int'(lk_owner[p*OWNER_W +: OWNER_W]) == m_ow[e], "R4", "owner",
            int'(lk_owner[p*OWNER_W +: OWNER_W]), m_ow[e]);
      end
    end
    @(posedge clk);
    if (wr_en && !(wr_alloc && m_full())) begin
      widx = wr_alloc ? m_free() : int'(wr_idx);
      m_v[widx] = wr_valid; m_tag[widx] = int'(wr_tag); m_set[widx] = int'(wr_set);
      m_st[widx] = int'(wr_state); m_sh[widx] = int'(wr_sharers); m_ow[widx] = int'(wr_owner);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(input bit alloc, input int idx, input bit v, input int t, input int s,
                    input int st);
    wr_en = 1; wr_alloc = alloc; wr_idx = IDX_W'(idx); wr_valid = v;
    wr_tag = TAG_W'(t); wr_set = SET_W'(s); wr_state = STATE_W'(st);
    wr_sharers = TILES'(st * 3); wr_owner = OWNER_W'(st);
  endtask

  task automatic q(input int p, input int t, input int s);
    q_tag[p] = TAG_W'(t); q_set[p] = SET_W'(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_set[i] = 0; m_st[i] = 0; m_sh[i] = 0; m_ow[i] = 0;
    end
    for (int p = 0; p < PORTS; p++) q(p, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    chk(full == 0, "R1", "full", int'(full), 0);
    chk(free_idx == 0, "R1", "free_idx", int'(free_idx), 0);
    chk(lk_hit == '0, "R1", "hits", int'(lk_hit), 0);
    @(negedge clk);

    // R6: allocate A at slot 0
    wr(1, 5, 1, 1, 0, 3); step();
    q(0, 1, 0); q(1, 1, 1); q(2, 2, 0); step();
    chk(obs_hit[0] == 1 && obs_idx[0] == 0, "R6", "alloc slot0", obs_idx[0], 0);
    chk(obs_hit[1] == 0 && obs_hit[2] == 0, "R2", "partial match miss",
        obs_hit[1] + obs_hit[2], 0);
    // R3: duplicate address in slot 1, lowest wins
    wr(1, 0, 1, 1, 0, 7); step();
    step();
    chk(obs_idx[0] == 0 && obs_st[0] == 3, "R3", "lowest dup", obs_idx[0], 0);
    // R9 / R7: update slot 0 while looking it up
    wr(0, 0, 1, 1, 0, 9); step();
    chk(obs_st[0] == 3, "R9", "pre-write contents", obs_st[0], 3);
    step();
    chk(obs_st[0] == 9, "R7", "updated state", obs_st[0], 9);
    // R8: release slot 0, lookup falls to slot 1, free returns to 0
    wr(0, 0, 0, 1, 0, 0); step();
    step();
    chk(obs_idx[0] == 1 && obs_st[0] == 7, "R8", "released slot skipped", obs_idx[0], 1);
    chk(free_idx == 0, "R8", "free after release", int'(free_idx), 0);
    // fill to full
    for (int k = 0; k < ENTRIES; k++) begin
      if (!m_full()) begin wr(1, 0, 1, 20 + k, 1, k); step(); end
    end
    step();
    chk(full == 1, "R5", "full after fill", int'(full), 1);
    // R10: allocate while full
    wr(1, 0, 1, 99, 2, 5); q(0, 99, 2); q(1, 1, 0); step();
    step();
    chk(obs_hit[0] == 0, "R10", "no write when full", obs_hit[0], 0);
    chk(obs_hit[1] == 1 && obs_idx[1] == 1, "R10", "live slot kept", obs_idx[1], 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 45) wr(1, 0, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 15)));
      else if (r < 65) wr(0, int'($urandom_range(0, ENTRIES-1)), 1,
                          int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                          int'($urandom_range(0, 15)));
      else if (r < 90) wr(0, int'($urandom_range(0, ENTRIES-1)), 0, 0, 0, 0);
      for (int p = 0; p < PORTS; p++)
        q(p, int'($urandom_range(0, 3)), int'($urandom_range(0, 1)));
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule